// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM with a 17-bit address, an 8-bit data bus, and two chip enables of opposite polarity (one active low, one active high). The RAM also has active-low output-enable and write-enable strobes. The host raises a request with an address, a write flag and write data. The sequencer turns the request into strobe edges in the right order. It holds each phase for a whole number of clock cycles, computed from the clock period and the RAM's nanosecond limits, then answers with a one-cycle acknowledge. For a read, the returned byte is valid from the acknowledge cycle onward.

Both chip enables stay inactive between accesses, which keeps the RAM in standby. The write path keeps output enable high throughout. It drives the data bus only after the RAM's release window following the write-enable fall, and it lets go of the bus in the cycle that write enable rises. A read holds both enables and output enable active for the longest of the access, output-enable and cycle times. The byte is captured on the clock edge that ends that count.

A sleep request taken while idle parks the RAM for supply reduction: both chip enables are held inactive and the bus is undriven. A wake request then starts a recovery count of one read-cycle time. Host requests are held off until that count runs out.

Top module: `asram_ctl`

## Requirements
- R1: When no access is in progress, the low-active chip enable is 1, the high-active chip enable is 0, output enable and write enable are 1, and the data driver is off.
- R2: A write uses one address-setup cycle with both chip enables active and write enable high. Write enable is then low for the turnaround and drive phases, output enable stays 1 for the whole write, and the address does not change while write enable is low.
- R3: Write enable stays low for at least 55 ns. The address is valid at least 60 ns before write enable rises, and the write data is driven at least 30 ns before that edge. After the write, the byte is stored at the address.
- R4: The data driver turns on only after write enable has been low for ceil(25 ns / clock) cycles. It turns off in the cycle that write enable rises, and it never overlaps the RAM driving the bus.
- R5: A read holds both chip enables active, output enable low and write enable high for max(ceil(70/clk), ceil(35/clk)) cycles. The byte on the bus is captured at the edge that ends this count and is presented on the read-data output.
- R6: Each accepted access produces exactly one acknowledge cycle. For a write, the acknowledge comes in the cycle write enable rises, with chip enables still active. For a read, it comes in the cycle after capture, with both chip enables and output enable already inactive.
- R7: A sleep request is taken only in the idle state. If a host request is present in the same cycle, the access is served first and the sleep request is dropped. A sleep request during an access is ignored.
- R8: While asleep, the sleeping output is 1, both chip enables are inactive, the driver is off, and host requests get no acknowledge.
- R9: A wake request while asleep keeps sleeping at 1 for ceil(70 ns / clock) further cycles. The block then goes idle and serves a pending request. A wake request while idle has no effect.
- R10: Under synchronous reset, all outputs take the R1 idle values, with acknowledge and sleeping at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, held until acknowledged |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| sleep_req | input | 1 | Enter retention standby (taken when idle) |
| wake_req | input | 1 | Leave retention standby |
| sleeping | output | 1 | Asleep or still recovering |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 1 | Low-active chip enable |
| mem_cs | output | 1 | High-active chip enable |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_drive | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
With a 10 ns clock, take the edge that accepts a write as edge 0. Write enable falls after edge 1, the driver turns on after edge 4, and write enable rises together with the acknowledge after edge 7. A read captures on edge 7 after its accepting edge, and the acknowledge and data appear right after that edge. After a wake, the block is idle 7 edges later. For each request the bench builds a queue with one expected strobe state per cycle, computed from the nanosecond limits. It compares this queue against the outputs at every falling clock edge. Meanwhile, a behavioural RAM measures the pulse widths, setup times and bus ownership in nanoseconds, and it supplies inverted data until the access time has passed.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ADDR_BITS = 17;
    localparam int DATA_BITS = 8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WR_SETUP,
        PH_WR_TURN,
        PH_WR_DRIVE,
        PH_WR_DONE,
        PH_RD_ACCESS,
        PH_RD_DONE,
        PH_SLEEP,
        PH_WAKE
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic we_n;
        logic drive;
        logic ack;
        logic asleep;
    } strobe_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels that belong to each phase.
    function automatic strobe_t strobes_of(input phase_e ph);
        strobe_t s;
        s = '{cs_n: 1'b1, cs: 1'b0, oe_n: 1'b1, we_n: 1'b1,
              drive: 1'b0, ack: 1'b0, asleep: 1'b0};
        case (ph)
            PH_WR_SETUP: begin
                s.cs_n = 1'b0; s.cs = 1'b1;
            end
            PH_WR_TURN: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.we_n = 1'b0;
            end
            PH_WR_DRIVE: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.we_n = 1'b0; s.drive = 1'b1;
            end
            PH_WR_DONE: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.ack = 1'b1;
            end
            PH_RD_ACCESS: begin
                s.cs_n = 1'b0; s.cs = 1'b1; s.oe_n = 1'b0;
            end
            PH_RD_DONE: begin
                s.ack = 1'b1;
            end
            PH_SLEEP, PH_WAKE: begin
                s.asleep = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int N_SETUP = 1,
    parameter int N_TURN  = 3,
    parameter int N_DRIVE = 3,
    parameter int N_READ  = 7,
    parameter int N_WAKE  = 7,
    parameter int CNT_W   = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   sleep_req,
    input  logic   wake_req,
    output phase_e phase_d,
    output logic   accept,
    output logic   capture
);

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               last;

    assign last    = (cnt_q == CNT_W'(1));
    assign accept  = (phase_q == PH_IDLE) && req_valid;
    assign capture = (phase_q == PH_RD_ACCESS) && last;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = (cnt_q > CNT_W'(0)) ? cnt_q - CNT_W'(1) : cnt_q;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    phase_d = req_write ? PH_WR_SETUP : PH_RD_ACCESS;
                    cnt_d   = req_write ? CNT_W'(N_SETUP) : CNT_W'(N_READ);
                end else if (sleep_req) begin
                    phase_d = PH_SLEEP;
                end
            end
            PH_WR_SETUP: if (last) begin
                phase_d = PH_WR_TURN;
                cnt_d   = CNT_W'(N_TURN);
            end
            PH_WR_TURN: if (last) begin
                phase_d = PH_WR_DRIVE;
                cnt_d   = CNT_W'(N_DRIVE);
            end
            PH_WR_DRIVE: if (last) begin
                phase_d = PH_WR_DONE;
            end
            PH_WR_DONE:   phase_d = PH_IDLE;
            PH_RD_ACCESS: if (last) begin
                phase_d = PH_RD_DONE;
            end
            PH_RD_DONE:   phase_d = PH_IDLE;
            PH_SLEEP: if (wake_req) begin
                phase_d = PH_WAKE;
                cnt_d   = CNT_W'(N_WAKE);
            end
            PH_WAKE: if (last) begin
                phase_d = PH_IDLE;
            end
            default:      phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/asram_pinreg.sv
module asram_pinreg
    import asram_pkg::*;
#(
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = DATA_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output strobe_t           strobe_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Strobes come straight from flops so the RAM never sees a glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= strobes_of(PH_IDLE);
        end else begin
            strobe_q <= strobes_of(phase_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = ADDR_BITS,
    parameter int DATA_W    = DATA_BITS,
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 0,   // address ahead of write enable fall
    parameter int T_WZ_NS   = 25,  // RAM bus release after write enable fall
    parameter int T_DS_NS   = 30,  // data ahead of write enable rise
    parameter int T_WP_NS   = 55,  // write enable low width
    parameter int T_AW_NS   = 60,  // address ahead of write enable rise
    parameter int T_CYC_NS  = 70,  // access cycle
    parameter int T_ACC_NS  = 70,  // address / enable to data
    parameter int T_OE_NS   = 35,  // output enable to data
    parameter int T_REC_NS  = 70   // recovery after supply return
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sleep_req,
    input  logic              wake_req,
    output logic              sleeping,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int N_SETUP = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int N_TURN  = ns_to_cyc(T_WZ_NS, CLK_NS);
    localparam int N_DS    = ns_to_cyc(T_DS_NS, CLK_NS);
    localparam int N_WP    = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int N_AW    = ns_to_cyc(T_AW_NS, CLK_NS);
    localparam int N_CYC   = ns_to_cyc(T_CYC_NS, CLK_NS);
    localparam int N_DRIVE = imax(1, imax(imax(N_DS, N_WP - N_TURN),
                                          imax(N_AW - N_SETUP - N_TURN,
                                               N_CYC - N_SETUP - N_TURN - 1)));
    localparam int N_READ  = imax(ns_to_cyc(T_ACC_NS, CLK_NS),
                                  imax(ns_to_cyc(T_OE_NS, CLK_NS), N_CYC));
    localparam int N_WAKE  = ns_to_cyc(T_REC_NS, CLK_NS);
    localparam int N_MAX   = imax(imax(N_SETUP, N_TURN),
                                  imax(N_DRIVE, imax(N_READ, N_WAKE)));
    localparam int CNT_W   = $clog2(N_MAX + 1);

    phase_e  phase_d;
    logic    accept;
    logic    capture;
    strobe_t strobe_q;

    asram_seq #(
        .N_SETUP (N_SETUP),
        .N_TURN  (N_TURN),
        .N_DRIVE (N_DRIVE),
        .N_READ  (N_READ),
        .N_WAKE  (N_WAKE),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (host_req),
        .req_write (host_write),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .phase_d   (phase_d),
        .accept    (accept),
        .capture   (capture)
    );

    asram_pinreg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pinreg (
        .clk       (clk),
        .rst       (rst),
        .phase_d   (phase_d),
        .accept    (accept),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .strobe_q  (strobe_q),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out)
    );

    asram_rdcap #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .dq_in   (mem_dq_in),
        .rdata_q (host_rdata)
    );

    assign mem_cs_n     = strobe_q.cs_n;
    assign mem_cs       = strobe_q.cs;
    assign mem_oe_n     = strobe_q.oe_n;
    assign mem_we_n     = strobe_q.we_n;
    assign mem_dq_drive = strobe_q.drive;
    assign host_ack     = strobe_q.ack;
    assign sleeping     = strobe_q.asleep;

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
    parameter int ADDR_W   = 17,
    parameter int TURN_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_drive,
    input logic              host_ack,
    input logic              sleeping
);

    int we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst || mem_we_n) begin
            we_low_cnt <= 0;
        end else if (we_low_cnt < 255) begin
            we_low_cnt <= we_low_cnt + 1;
        end
    end

    // R1: the two chip enables always agree on selected / deselected
    a_r1_enables_pair: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n == !mem_cs);

    // R2: write enable low only inside a selected write with output enable high
    a_r2_we_needs_cs: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));

    // R2: the address holds while write enable is low
    a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> $stable(mem_addr));

    // R4: the driver waits for the RAM's release window
    a_r4_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_drive) |-> (we_low_cnt >= TURN_CYC));

    // R4: the driver lets go when write enable rises
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_dq_drive);

    // R4: the driver is only on inside a write
    a_r4_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        mem_dq_drive |-> (!mem_we_n && mem_oe_n));

    // R6: acknowledge lasts one cycle
    a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R8: sleeping keeps the RAM deselected and the host unanswered
    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> (mem_cs_n && !mem_cs && !mem_dq_drive && !host_ack));

endmodule

bind asram_ctl asram_chk #(
    .ADDR_W   (ADDR_W),
    .TURN_CYC (N_TURN)
) u_asram_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_addr     (mem_addr),
    .mem_cs_n     (mem_cs_n),
    .mem_cs       (mem_cs),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_dq_drive (mem_dq_drive),
    .host_ack     (host_ack),
    .sleeping     (sleeping)
);

// File: tb/asram_ctl_bench.sv
`timescale 1ns/1ps
module asram_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int C_SETUP = cyc(0);
    localparam int C_TURN  = cyc(25);
    localparam int C_DRIVE = mx(mx(cyc(30), cyc(55) - C_TURN),
                                mx(cyc(60) - C_SETUP - C_TURN,
                                   cyc(70) - C_SETUP - C_TURN - 1));
    localparam int C_READ  = mx(cyc(70), mx(cyc(35), cyc(70)));
    localparam int C_REC   = cyc(70);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        sleep_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        sleeping;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_drive;
    logic [7:0]  mem_dq_in = '0;

    always #(HALF) clk = ~clk;

    asram_ctl #(.CLK_NS(CLK_PERIOD)) u_asram_ctl (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .sleep_req(sleep_req), .wake_req(wake_req), .sleeping(sleeping),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // ---------------- behavioural RAM ----------------
    logic [7:0] ram [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] ramval(input logic [16:0] a);
        if (ram.exists(int'(a))) return ram[int'(a)];
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] refval(input logic [16:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return a[7:0] ^ 8'h5A;
    endfunction

    longint t_now, t_addr, t_wstart, t_drv, t_rd, bus_free;
    bit     p_wr, p_rd, p_drv, m_act, m_wr, m_rd, m_valid;
    logic [16:0] p_addr;
    logic [7:0]  p_dq;

    always @(negedge clk) begin
        t_now = longint'($time);
        if (rst) begin
            p_wr = 0; p_rd = 0; p_drv = 0; p_addr = mem_addr; p_dq = '0;
            t_addr = t_now; t_wstart = t_now; t_drv = t_now; t_rd = t_now;
            bus_free = 0;
        end else begin
            m_act = !mem_cs_n && mem_cs;
            m_wr  = m_act && !mem_we_n;
            m_rd  = m_act && !mem_oe_n && mem_we_n;
            if (mem_addr != p_addr) begin
                if (m_wr && p_wr)
                    check(1'b0, "R2", "address moved during write",
                          longint'(mem_addr), longint'(p_addr));
                t_addr = t_now;
            end
            if (m_wr && !p_wr) t_wstart = t_now;
            if (mem_dq_drive && !p_drv) t_drv = t_now;
            if (mem_dq_drive)
                check((t_now - HALF) >= bus_free, "R4", "bus contention ns",
                      t_now - HALF, bus_free);
            if (p_wr && !m_wr) begin
                check((t_now - t_wstart) >= 55, "R3", "write pulse ns",
                      t_now - t_wstart, 55);
                check((t_now - t_addr) >= 60, "R3", "address setup ns",
                      t_now - t_addr, 60);
                check(p_drv && ((t_now - t_drv) >= 30), "R3", "data setup ns",
                      t_now - t_drv, 30);
                ram[int'(p_addr)] = p_dq;
            end
            if (m_rd) begin
                if (!p_rd) t_rd = t_now;
                bus_free = t_now + HALF + 25;
            end
            m_valid = m_rd && ((t_now - t_rd + CLK_PERIOD) >= 70)
                           && ((t_now - t_addr + CLK_PERIOD) >= 70);
            mem_dq_in = m_valid ? ramval(mem_addr) : ~ramval(mem_addr);
            p_wr = m_wr; p_rd = m_rd; p_drv = mem_dq_drive;
            p_addr = mem_addr; p_dq = mem_dq_out;
        end
    end

    // ---------------- cycle reference ----------------
    typedef struct {
        bit          act;
        bit          oe_n;
        bit          we_n;
        bit          drv;
        bit          ack;
        bit          slp;
        bit          chk_rd;
        logic [7:0]  rd;
        logic [16:0] addr;
        logic [7:0]  wd;
        string       tag;
    } exp_t;

    exp_t expq[$];
    bit   exp_sleep = 0;

    function automatic exp_t quiet(input bit slp, input string tag);
        exp_t e;
        e.act = 0; e.oe_n = 1; e.we_n = 1; e.drv = 0; e.ack = 0; e.slp = slp;
        e.chk_rd = 0; e.rd = '0; e.addr = '0; e.wd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic push_write(input logic [16:0] a, input logic [7:0] d);
        exp_t e;
        e = quiet(0, "R2"); e.act = 1; e.addr = a; e.wd = d;
        for (int i = 0; i < C_SETUP; i++) expq.push_back(e);
        e.we_n = 0;
        for (int i = 0; i < C_TURN; i++) expq.push_back(e);
        e.drv = 1; e.tag = "R3";
        for (int i = 0; i < C_DRIVE; i++) expq.push_back(e);
        e.drv = 0; e.we_n = 1; e.ack = 1; e.tag = "R6";
        expq.push_back(e);
        ref_mem[int'(a)] = d;
    endtask

    task automatic push_read(input logic [16:0] a);
        exp_t e;
        e = quiet(0, "R5"); e.act = 1; e.oe_n = 0; e.addr = a;
        for (int i = 0; i < C_READ; i++) expq.push_back(e);
        e = quiet(0, "R6"); e.ack = 1; e.chk_rd = 1; e.rd = refval(a);
        expq.push_back(e);
    endtask

    task automatic step();
        exp_t e;
        logic [6:0] a, x;
        @(negedge clk);
        if (expq.size() > 0) e = expq.pop_front();
        else e = quiet(exp_sleep, exp_sleep ? "R8" : "R1");
        a = {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_drive, host_ack, sleeping};
        x = {!e.act, e.act, e.oe_n, e.we_n, e.drv, e.ack, e.slp};
        check(a == x, e.tag, "strobes {cs_n,cs,oe_n,we_n,drive,ack,sleeping}",
              longint'(a), longint'(x));
        if (e.act)
            check(mem_addr == e.addr, "R2", "address", longint'(mem_addr), longint'(e.addr));
        if (e.drv)
            check(mem_dq_out == e.wd, "R3", "write data", longint'(mem_dq_out), longint'(e.wd));
        if (e.chk_rd)
            check(host_rdata == e.rd, "R5", "read data", longint'(host_rdata), longint'(e.rd));
        if (host_ack) host_req = 1'b0;
        sleep_req = 1'b0;
        wake_req  = 1'b0;
    endtask

    task automatic drain(input int poke_sleep);
        int k;
        k = 0;
        while (expq.size() > 0) begin
            step();
            k++;
            if (k == poke_sleep) sleep_req = 1'b1;
        end
        step();
    endtask

    task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
        host_req = 1'b1; host_write = w; host_addr = a; host_wdata = d;
        if (w) push_write(a, d);
        else   push_read(a);
    endtask

    task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d);
        issue(w, a, d);
        drain(0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    logic [16:0] pool [8];

    initial begin
        pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h00005;
        pool[3] = 17'h01234; pool[4] = 17'h0ABCD; pool[5] = 17'h10000;
        pool[6] = 17'h0FFFF; pool[7] = 17'h00080;

        // R10: reset values
        repeat (2) @(negedge clk);
        expq.push_back(quiet(0, "R10"));
        expq.push_back(quiet(0, "R10"));
        step();
        rst = 1'b0;
        step();
        step();

        // R3 / R5: directed writes and reads at the address extremes
        access(1, 17'h00000, 8'hA5);
        access(1, 17'h1FFFF, 8'h3C);
        access(0, 17'h00000, 8'h00);
        access(0, 17'h1FFFF, 8'h00);
        access(0, 17'h00042, 8'h00);   // never written: default byte

        // R3 / R5: random read-after-write
        for (int i = 0; i < 24; i++) begin
            logic [16:0] a;
            a = pool[$urandom_range(0, 7)];
            if ($urandom_range(0, 1) == 1) begin
                access(1, a, 8'($urandom_range(0, 255)));
                access(0, a, 8'h00);
            end else begin
                access(0, a, 8'h00);
            end
        end

        // R7: request and sleep together in idle: access wins, sleep dropped
        sleep_req = 1'b1;
        issue(1, 17'h00777, 8'h81);
        drain(0);
        expq.push_back(quiet(0, "R7"));
        step();

        // R7: sleep during an access is ignored
        issue(0, 17'h00777, 8'h00);
        drain(2);
        expq.push_back(quiet(0, "R7"));
        expq.push_back(quiet(0, "R7"));
        step();
        step();

        // R9: wake while idle has no effect
        wake_req = 1'b1;
        expq.push_back(quiet(0, "R9"));
        expq.push_back(quiet(0, "R9"));
        step();
        step();

        // R8: enter sleep, host request left unanswered
        sleep_req = 1'b1;
        exp_sleep = 1;
        step();
        step();
        host_req = 1'b1; host_write = 1'b0; host_addr = 17'h00777;
        repeat (6) step();

        // R9: wake, recovery count, then the pending read is served
        wake_req = 1'b1;
        for (int i = 0; i < C_REC; i++) expq.push_back(quiet(1, "R9"));
        expq.push_back(quiet(0, "R9"));
        push_read(17'h00777);
        exp_sleep = 0;
        drain(0);

        // R2 / R5: back-to-back after wake
        access(1, 17'h0ABCD, 8'h5E);
        access(0, 17'h0ABCD, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule